// File: doc/BRIEF.md
# Weighted Frame Slot Arbiter

This block assembles one outgoing link frame per frame tick from a configurable number of service queues. Each service offers a payload chunk through a valid/ready pair, together with a flag that marks the final chunk of its transfer. A weighted round-robin arbiter decides which service fills the user-data field of each frame. Over a full round, each service receives as many slots as its weight. Transfers wider than one chunk are sent over consecutive grants without being broken up by other services.

An event field bypasses arbitration completely. The event input is sampled on every frame tick and placed in the frame word that appears on the next clock, whether or not any payload is granted. The frame tick is driven from outside at the link frame rate, for example once every five cycles of a 200 MHz clock for a 40 MHz frame rate. The frame word then goes to a serializer, which is not part of this block.

Top module: `wslot_framer`

## Requirements
- R1: After reset, `frame_stb` is 0, `frame_out` is all zeros, no `svc_ready` bit is set while `frame_tick` is low, and every credit is empty. The first frame tick therefore reloads all credits from the weights and starts the search at service 0.
- R2: `frame_stb` is high for exactly the one cycle that follows each cycle with `frame_tick` high, and is low at all other times.
- R3: The event field of each frame equals `evt_in` as sampled in the tick cycle, in every frame, whether or not payload is granted.
- R4: At most one `svc_ready` bit is set at a time. A bit is set only in a tick cycle, and only for a service whose `svc_valid` is high. A chunk is transferred when ready and valid are both high.
- R5: With all services valid and sending single-chunk transfers, the first round after reset gives each service exactly as many frames as its weight, where the round length is the sum of the weights. A service whose weight is 0 is never granted.
- R6: Outside a locked transfer, the search order starts at the service after the last one granted and wraps from N_SVC-1 to 0. A service takes part only if it is valid and has a non-zero credit. When no valid service holds a credit, all credits are reloaded from the weights in that same cycle, and the granted service's credit is then reduced by 1.
- R7: A service that is not valid is skipped in the same tick. Whenever some valid service is eligible, the frame carries payload.
- R8: When nothing is granted, the frame has the payload-valid bit at 0, the service ID at 0 and the chunk field at 0.
- R9: After a chunk is granted with `svc_last` low, only that service can be granted until its chunk with `svc_last` high has been sent. If that service is not valid at a tick, the frame is empty.
- R10: The frame word layout is: chunk in bits [CHUNK_W-1:0], service ID in the next ID_W bits, the payload-valid bit above the ID, and the event field in the top EVT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | High for one cycle per frame period |
| evt_in | input | EVT_W | Event bits carried in every frame |
| svc_valid | input | N_SVC | Per-service chunk available |
| svc_last | input | N_SVC | Per-service flag marking the offered chunk as the final one of its transfer |
| svc_data | input | N_SVC*CHUNK_W | Per-service chunk; service i occupies bits [i*CHUNK_W +: CHUNK_W] |
| svc_weight | input | N_SVC*WEIGHT_W | Per-service weight; service i occupies bits [i*WEIGHT_W +: WEIGHT_W] |
| svc_ready | output | N_SVC | One-hot grant; the chunk is taken at this tick |
| frame_stb | output | 1 | Frame word valid, one cycle after each tick |
| frame_out | output | EVT_W+1+ID_W+CHUNK_W | Assembled frame word |

## Verification
The bench runs every combination of weights 0 to 3 across three services and counts the grants in the first round. A wrong reload rule would give a skewed share, and a weight-0 service could steal slots. Starting the search at the wrong index shows up as a wrong frame order. With one service idle, each frame must still carry payload; an arbiter that does not skip idle services leaves empty slots. Multi-chunk transfers are combined with pseudo-random stalls. A design that drops the lock lets another service's chunk cut into a transfer, and one that keeps the lock too long starves the other services. The event field is compared on every frame, so event bits that are delayed or that depend on a grant are caught.

// File: rtl/wslot_framer.sv
module wslot_framer #(
  parameter int N_SVC    = 3,
  parameter int CHUNK_W  = 16,
  parameter int EVT_W    = 4,
  parameter int WEIGHT_W = 4,
  localparam int ID_W    = (N_SVC > 1) ? $clog2(N_SVC) : 1,
  localparam int FRAME_W = EVT_W + 1 + ID_W + CHUNK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_tick,
  input  logic [EVT_W-1:0]            evt_in,
  input  logic [N_SVC-1:0]            svc_valid,
  input  logic [N_SVC-1:0]            svc_last,
  input  logic [N_SVC*CHUNK_W-1:0]    svc_data,
  input  logic [N_SVC*WEIGHT_W-1:0]   svc_weight,
  output logic [N_SVC-1:0]            svc_ready,
  output logic                        frame_stb,
  output logic [FRAME_W-1:0]          frame_out
);

  logic [WEIGHT_W-1:0] cred_q [N_SVC];
  logic [WEIGHT_W-1:0] eff    [N_SVC];
  logic [ID_W-1:0]     ptr_q, lock_id_q, pick, gnt_id;
  logic                lock_q, found, need_reload, gnt_ok, gnt_last;
  logic [N_SVC-1:0]    has_cred, elig, zero_w;
  logic [CHUNK_W-1:0]  gnt_data;

  always_comb begin
    for (int i = 0; i < N_SVC; i++) begin
      has_cred[i] = svc_valid[i] && (cred_q[i] != '0);
      zero_w[i]   = (svc_weight[i*WEIGHT_W +: WEIGHT_W] == '0);
    end
    need_reload = ~|has_cred;
    for (int i = 0; i < N_SVC; i++) begin
      eff[i]  = need_reload ? svc_weight[i*WEIGHT_W +: WEIGHT_W] : cred_q[i];
      elig[i] = svc_valid[i] && (eff[i] != '0);
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N_SVC; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N_SVC;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = ID_W'(idx);
      end
    end
  end

  assign gnt_id   = lock_q ? lock_id_q : pick;
  assign gnt_ok   = frame_tick && (lock_q ? svc_valid[lock_id_q] : found);
  assign gnt_data = svc_data[gnt_id*CHUNK_W +: CHUNK_W];
  assign gnt_last = svc_last[gnt_id];

  always_comb
    for (int i = 0; i < N_SVC; i++)
      svc_ready[i] = gnt_ok && (gnt_id == ID_W'(i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SVC; i++) cred_q[i] <= '0;
      ptr_q     <= ID_W'(N_SVC - 1);
      lock_q    <= 1'b0;
      lock_id_q <= '0;
      frame_stb <= 1'b0;
      frame_out <= '0;
    end else begin
      frame_stb <= frame_tick;
      if (frame_tick)
        frame_out <= {evt_in, gnt_ok, gnt_ok ? gnt_id : ID_W'(0),
                      gnt_ok ? gnt_data : CHUNK_W'(0)};
      if (gnt_ok) begin
        if (lock_q) begin
          if (cred_q[gnt_id] != '0) cred_q[gnt_id] <= cred_q[gnt_id] - 1'b1;
        end else begin
          for (int i = 0; i < N_SVC; i++)
            cred_q[i] <= (gnt_id == ID_W'(i)) ? eff[i] - 1'b1 : eff[i];
          ptr_q <= gnt_id;
        end
        lock_q    <= !gnt_last;
        lock_id_q <= gnt_id;
      end
    end
  end

  assert_ready_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_ready) && (svc_ready == '0 || frame_tick) && ((svc_ready & ~svc_valid) == '0));

  assert_stb_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frame_stb);

  assert_stb_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> !frame_stb);

  assert_evt_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frame_out[FRAME_W-1 -: EVT_W] == $past(evt_in));

  assert_empty_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !frame_out[CHUNK_W+ID_W]) |-> (frame_out[CHUNK_W+ID_W-1:0] == '0));

  assert_zero_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ready & zero_w) == '0);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (svc_ready == '0 || svc_ready[lock_id_q]));

endmodule

// File: tb/wslot_framer_tb.sv
`timescale 1ns/1ps
module wslot_framer_tb_top;
  localparam int N = 3, CW = 16, EW = 4, WW = 4, IW = 2;
  localparam int FW = EW + 1 + IW + CW;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [EW-1:0] evt = '0;
  logic [N-1:0] valid = '0, last = '0, ready;
  logic [N*CW-1:0] data = '0;
  logic [N*WW-1:0] weight = '0;
  logic stb;
  logic [FW-1:0] fout;

  always #2.5 clk = ~clk;

  wslot_framer #(.N_SVC(N), .CHUNK_W(CW), .EVT_W(EW), .WEIGHT_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(tick), .evt_in(evt),
    .svc_valid(valid), .svc_last(last), .svc_data(data), .svc_weight(weight),
    .svc_ready(ready), .frame_stb(stb), .frame_out(fout));

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  int w [N], len [N], idx [N], seq [N], cnt [N];
  bit act [N];
  logic [N-1:0] hold = '0;
  bit rnd_hold = 0;
  int mc [N], mptr, mlid, adv;
  bit mlk, exp_pend;
  logic [FW-1:0] exp_word;
  logic [15:0] lf = 16'hACE1;
  int pay_frames;
  bit dlk; int dlid;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic drive_inputs();
    for (int i = 0; i < N; i++) begin
      valid[i] = act[i] && !hold[i];
      data[i*CW +: CW] = {4'(i), 12'(seq[i])};
      last[i] = (idx[i] == len[i] - 1);
      weight[i*WW +: WW] = WW'(w[i]);
    end
  endtask

  task automatic model_step(output int gid);
    bit any;
    int e [N];
    gid = -1;
    if (mlk) begin
      if (valid[mlid]) begin
        gid = mlid;
        if (mc[gid] > 0) mc[gid]--;
      end
    end else begin
      any = 0;
      for (int i = 0; i < N; i++) if (valid[i] && mc[i] > 0) any = 1;
      for (int i = 0; i < N; i++) e[i] = any ? mc[i] : w[i];
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (mptr + k) % N;
        if (gid < 0 && valid[j] && e[j] > 0) gid = j;
      end
      if (gid >= 0) begin
        for (int i = 0; i < N; i++) mc[i] = e[i];
        mc[gid]--;
        mptr = gid;
      end
    end
    if (gid >= 0) begin
      mlk = !last[gid];
      mlid = gid;
    end
  endtask

  task automatic check_prev();
    if (exp_pend) begin
      chk(stb === 1'b1, "R2", "strobe after tick", stb, 1);
      chk(fout[FW-1 -: EW] === exp_word[FW-1 -: EW], "R3", "event field", fout[FW-1 -: EW], exp_word[FW-1 -: EW]);
      chk(fout[FW-EW-1:0] === exp_word[FW-EW-1:0], "R10", "payload/id/chunk", fout[FW-EW-1:0], exp_word[FW-EW-1:0]);
      if (fout[CW+IW]) pay_frames++;
    end else
      chk(stb === 1'b0, "R2", "strobe idle", stb, 0);
    exp_pend = 0;
    if (adv >= 0) begin
      seq[adv]++;
      idx[adv] = (idx[adv] == len[adv] - 1) ? 0 : idx[adv] + 1;
      adv = -1;
    end
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      int g;
      logic [N-1:0] em;
      @(negedge clk);
      check_prev();
      tick = (cyc % 5 == 0);
      cyc++;
      lf = lf_next(lf);
      evt = lf[EW-1:0];
      if (rnd_hold && tick) hold = lf[7:5] & lf[11:9];
      drive_inputs();
      #1;
      if (tick) begin
        if (dlk) chk(ready == '0 || ready[dlid], "R9", "grant stays with locked service", ready, 1 << dlid);
        model_step(g);
        em = (g >= 0) ? N'(1 << g) : '0;
        chk(ready === em, "R4", "ready mask", ready, em);
        for (int i = 0; i < N; i++) if (ready[i]) begin
          cnt[i]++;
          dlk = !last[i];
          dlid = i;
        end
        exp_word = {evt, g >= 0, (g >= 0) ? IW'(g) : IW'(0),
                    (g >= 0) ? data[g*CW +: CW] : CW'(0)};
        exp_pend = 1;
        adv = g;
      end else
        chk(ready === '0, "R4", "no ready outside tick", ready, 0);
    end
    @(negedge clk);
    check_prev();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0;
    for (int i = 0; i < N; i++) begin
      idx[i] = 0; seq[i] = 0; cnt[i] = 0; mc[i] = 0;
    end
    hold = '0;
    drive_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk(stb === 1'b0 && fout === '0, "R1", "reset outputs", fout, 0);
    chk(ready === '0, "R1", "reset ready", ready, 0);
    mptr = N - 1; mlk = 0; mlid = 0; adv = -1; exp_pend = 0;
    dlk = 0; dlid = 0; cyc = 0; pay_frames = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin w[i] = 1; len[i] = 1; act[i] = 1; end
    // R5 R6 R8: every weight combination 0..3
    for (int combo = 0; combo < 64; combo++) begin
      int s;
      w[0] = combo % 4; w[1] = (combo / 4) % 4; w[2] = combo / 16;
      for (int i = 0; i < N; i++) begin len[i] = 1; act[i] = 1; end
      rnd_hold = 0;
      do_reset();
      s = w[0] + w[1] + w[2];
      run_cycles(5 * ((s == 0) ? 3 : s));
      for (int i = 0; i < N; i++)
        chk(cnt[i] == w[i], "R5", $sformatf("share of service %0d", i), cnt[i], w[i]);
      if (s == 0) chk(pay_frames == 0, "R8", "no payload with zero weights", pay_frames, 0);
    end
    // R7: idle service skipped, no empty slot
    w[0] = 2; w[1] = 2; w[2] = 2;
    act[0] = 1; act[1] = 0; act[2] = 1;
    do_reset();
    run_cycles(5 * 12);
    chk(pay_frames == 12, "R7", "all frames carry payload", pay_frames, 12);
    chk(cnt[1] == 0, "R7", "idle service never granted", cnt[1], 0);
    // R9: multi-chunk transfers
    w[0] = 1; w[1] = 1; w[2] = 1;
    len[0] = 1; len[1] = 3; len[2] = 2;
    act[0] = 1; act[1] = 1; act[2] = 1;
    do_reset();
    run_cycles(5 * 30);
    chk(pay_frames == 30, "R9", "locked transfers still fill frames", pay_frames, 30);
    // R6 R9: random stalls, lengths and weights
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        lf = lf_next(lf);
        w[i] = lf[1:0] + ((r == 0) ? 1 : 0);
        len[i] = 1 + lf[3:2];
        act[i] = 1;
      end
      rnd_hold = 1;
      do_reset();
      run_cycles(5 * 60);
    end
    rnd_hold = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule